// File: doc/BRIEF.md
# Burst Memory Bus Master

This block moves 32-bit words between internal channel FIFOs and host memory over a synchronous address/data bus. A requester hands it a start word address, a word count and a direction. The block requests the bus, waits for a grant and then carries out the transfer as a series of bus transactions. Each transaction is either a single word or a burst of 4 or 8 words, as set by a configuration bit. The run is split so that a burst always starts on a block boundary of its own length. A burst therefore never leaves its aligned block, and never leaves the memory page, whose size is a multiple of 8 words.

Every transaction opens with a one-cycle address phase. The start address is driven on dedicated address outputs. A configuration bit can also place it on the data lines, for older memory controllers. The three low word-address bits that change inside a burst have their own outputs and step on every completed beat. Memory paces each beat with a ready input: a beat is done at a clock edge where ready is high, and one word per clock is the fastest rate. Byte order on the data lines can be reversed by a static configuration bit. Every byte carries an odd parity bit. Parity is generated on writes and checked on reads.

When the last beat completes, the block drops its bus request and returns a one-cycle done pulse with the number of words moved.

Top module: `burst_bus_master`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request accepted with a word count of zero gives `done` high in the next cycle with `done_words` = 0, and raises no bus request.
- R2: `bus_req` rises in the cycle after a non-zero request is accepted. `bus_as` is never high unless `bus_gnt` was seen while `bus_req` was high. `bus_req` is low in the cycle that follows the last completed beat.
- R3: Each transaction starts with exactly one cycle of `bus_as`, with `bus_addr` = the transaction's first word address and `bus_burst` = 1 for a multi-word burst. When `cfg_addr_on_data` = 1, that cycle also has `bus_oe` = 1 and `bus_dout` = the address zero-extended to 32 bits.
- R4: The burst length is 8 words when `cfg_burst8` = 1 and 4 when it is 0. From the current word address, the block issues single-word transactions until the address is a multiple of the burst length. It then issues full bursts while at least a burst length of words remains, and single words for what is left.
- R5: A burst's first address is a multiple of its length, so no transaction crosses an aligned block or a page of `PAGE_WORDS` words.
- R6: During the data phase, `bus_alo` carries the low three bits of the current beat's word address. The full beat address is {`bus_addr`[AW-1:3], `bus_alo`}, and it advances by one per completed beat.
- R7: A beat completes only at a clock edge where `bus_rdy` = 1. With `bus_rdy` = 0, `bus_alo` and the phase hold, and neither FIFO strobe is raised.
- R8: On a write, each completing beat has `fifo_rd_en` = 1 and `bus_oe` = 1. `bus_dout` is `fifo_rd_data` as is, or with bytes 0↔3 and 1↔2 exchanged when `cfg_big_endian` = 1.
- R9: On a read, each completing beat has `fifo_wr_en` = 1, with `fifo_wr_data` = `bus_din` under the same byte-order rule as R8.
- R10: Parity is odd per byte: `bus_pout`[i] makes byte i of `bus_dout` (bits 8i+7..8i) plus that bit hold an odd number of ones. On a read beat, a `bus_pin` bit that breaks this rule sets `par_err`, which then stays high until reset.
- R11: `done` is a one-cycle pulse in the cycle after the final beat, with `done_words` equal to the requested count.
- R12: While reset is held and after it is released, `req_ready` = 1 and `bus_req`, `bus_as`, `done` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cfg_burst8 | input | 1 | 1: 8-word bursts, 0: 4-word bursts |
| cfg_big_endian | input | 1 | Reverse byte order between FIFO and bus |
| cfg_addr_on_data | input | 1 | Also drive the address on the data lines in the address phase |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | AW | First word address |
| req_count | input | CW | Number of words |
| req_write | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| fifo_rd_en | output | 1 | Pop the outgoing FIFO word |
| fifo_rd_data | input | 32 | Outgoing FIFO head word (show-ahead) |
| fifo_wr_en | output | 1 | Push a received word |
| fifo_wr_data | output | 32 | Received word |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_as | output | 1 | Address phase strobe |
| bus_burst | output | 1 | Transaction is a multi-word burst |
| bus_we | output | 1 | Transaction direction, 1 = write |
| bus_addr | output | AW | Transaction start word address |
| bus_alo | output | 3 | Low word-address bits of the current beat |
| bus_oe | output | 1 | Data lines driven by the block |
| bus_dout | output | 32 | Outgoing address/data |
| bus_pout | output | 4 | Outgoing odd byte parity |
| bus_din | input | 32 | Incoming read data |
| bus_pin | input | 4 | Incoming byte parity |
| bus_rdy | input | 1 | Memory ready, completes the current beat |
| done | output | 1 | Transfer finished pulse |
| done_words | output | CW | Words moved by the finished transfer |
| par_err | output | 1 | Sticky read parity error |

## Verification
The assertions assume that `bus_gnt` stays high for as long as `bus_req` is high, and that `req_valid` is raised only while `req_ready` is high. They also assume that `bus_rdy` may be low in any data-phase cycle, but that memory never leaves it low for good. The bench keeps to these rules. Its grant follows the request half a cycle later and stays up until the request falls. Each request is held for a single idle cycle. Ready comes either from an LFSR pattern, which lets only short stalls through, or is held high. Start addresses and counts are chosen so that no transfer wraps past the top of the address space.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int BBM_DW = 32;
  localparam int BBM_NB = BBM_DW / 8;
  localparam int BBM_LO = 3;  // address bits that cycle inside the longest burst
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_ADDR, ST_DATA} bbm_state_e;
endpackage

// File: rtl/bbm_chunk.sv
// Picks the length of the next transaction from the current address and the
// words still to move.
module bbm_chunk import bbm_pkg::*; #(
  parameter int CW = 16,
  parameter int LW = 4
) (
  input  logic [BBM_LO-1:0] addr_lo,
  input  logic [CW-1:0]     remaining,
  input  logic              burst8,
  output logic [LW-1:0]     chunk
);
  logic [LW-1:0]     blen;
  logic [BBM_LO-1:0] mask;
  logic              aligned;
  logic              enough;

  always_comb begin
    blen    = burst8 ? LW'(8) : LW'(4);
    mask    = BBM_LO'(blen - LW'(1));
    aligned = (addr_lo & mask) == '0;
    enough  = remaining >= CW'(blen);
    chunk   = (aligned && enough) ? blen : LW'(1);
  end
endmodule

// File: rtl/bbm_swap.sv
// Static byte-order reversal between the FIFO side and the bus side.
module bbm_swap #(
  parameter int NB = 4
) (
  input  logic            big,
  input  logic [8*NB-1:0] din,
  output logic [8*NB-1:0] dout
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = big ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/bbm_parity.sv
// Odd parity, one bit per byte lane.
module bbm_parity #(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] word,
  output logic [NB-1:0]   par
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign par[b] = ~^word[8*b +: 8];
  end
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master import bbm_pkg::*; #(
  parameter int AW         = 30,
  parameter int CW         = 16,
  parameter int PAGE_WORDS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_burst8,
  input  logic                cfg_big_endian,
  input  logic                cfg_addr_on_data,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic [CW-1:0]       req_count,
  input  logic                req_write,
  output logic                fifo_rd_en,
  input  logic [BBM_DW-1:0]   fifo_rd_data,
  output logic                fifo_wr_en,
  output logic [BBM_DW-1:0]   fifo_wr_data,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_as,
  output logic                bus_burst,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [BBM_LO-1:0]   bus_alo,
  output logic                bus_oe,
  output logic [BBM_DW-1:0]   bus_dout,
  output logic [BBM_NB-1:0]   bus_pout,
  input  logic [BBM_DW-1:0]   bus_din,
  input  logic [BBM_NB-1:0]   bus_pin,
  input  logic                bus_rdy,
  output logic                done,
  output logic [CW-1:0]       done_words,
  output logic                par_err
);
  localparam int LW      = 4;
  localparam int PAGE_LG = $clog2(PAGE_WORDS);
  localparam int PADW    = BBM_DW - AW;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  bbm_state_e      state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d, base_q;
  logic [CW-1:0]   rem_q, rem_d, total_q, donew_q, donew_d;
  logic [LW-1:0]   beats_q, chunk;
  logic            we_q, done_q, done_d, perr_q, perr_d;
  logic            accept, beat, last_beat, final_beat, ctx_en;
  logic            in_addr, in_data, rd_bad;
  logic [BBM_DW-1:0] tx_word, rx_word, dout_pre;
  logic [BBM_NB-1:0] rx_par;

  bbm_chunk #(.CW(CW), .LW(LW)) u_chunk (
    .addr_lo  (addr_q[BBM_LO-1:0]),
    .remaining(rem_q),
    .burst8   (cfg_burst8),
    .chunk    (chunk)
  );

  bbm_swap #(.NB(BBM_NB)) u_tx_swap (.big(cfg_big_endian), .din(fifo_rd_data), .dout(tx_word));
  bbm_swap #(.NB(BBM_NB)) u_rx_swap (.big(cfg_big_endian), .din(bus_din),      .dout(rx_word));
  bbm_parity #(.NB(BBM_NB)) u_tx_par (.word(bus_dout), .par(bus_pout));
  bbm_parity #(.NB(BBM_NB)) u_rx_par (.word(bus_din),  .par(rx_par));

  // next-state logic
  always_comb begin
    in_addr    = (state_q == ST_ADDR);
    in_data    = (state_q == ST_DATA);
    accept     = (state_q == ST_IDLE) && req_valid;
    beat       = in_data && bus_rdy;
    last_beat  = beat && (beats_q == LW'(1));
    final_beat = last_beat && (rem_q == CW'(1));
    ctx_en     = accept || beat;
    addr_d     = accept ? req_addr  : addr_q + AW'(1);
    rem_d      = accept ? req_count : rem_q - CW'(1);
    done_d     = (accept && (req_count == '0)) || final_beat;
    donew_d    = accept ? '0 : total_q;
    rd_bad     = rx_par != bus_pin;
    perr_d     = perr_q || (beat && !we_q && rd_bad);

    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && (req_count != '0)) state_d = ST_ARB;
      ST_ARB:  if (bus_gnt) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (final_beat)     state_d = ST_IDLE;
               else if (last_beat) state_d = ST_ADDR;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      rem_q   <= '0;
      total_q <= '0;
      beats_q <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      donew_q <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      perr_q  <= perr_d;
      if (ctx_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      if (accept) begin
        we_q    <= req_write;
        total_q <= req_count;
      end
      if (in_addr) begin
        base_q  <= addr_q;
        beats_q <= chunk;
      end else if (beat) begin
        beats_q <= beats_q - LW'(1);
      end
      if (done_d) donew_q <= donew_d;
    end
  end

  // outputs
  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    bus_req      = (state_q != ST_IDLE);
    bus_as       = in_addr;
    bus_burst    = in_addr && (chunk != LW'(1));
    bus_we       = (in_addr || in_data) && we_q;
    bus_addr     = in_addr ? addr_q : base_q;
    bus_alo      = addr_q[BBM_LO-1:0];
    bus_oe       = (in_addr && cfg_addr_on_data) || (in_data && we_q);
    dout_pre     = in_addr ? {{PADW{1'b0}}, addr_q} : tx_word;
    bus_dout     = bus_oe ? dout_pre : '0;
    fifo_rd_en   = beat && we_q;
    fifo_wr_en   = beat && !we_q;
    fifo_wr_data = rx_word;
    done         = done_q;
    done_words   = donew_q;
    par_err      = perr_q;
  end

  logic [AW-1:0] chunk_last;
  assign chunk_last = addr_q + AW'(chunk) - AW'(1);

  // R2
  as_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_i)
    bus_as |-> (bus_req && $past(bus_gnt)));
  // R3
  as_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_i)
    bus_as |=> !bus_as);
  // R5
  burst_aligned_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_as && bus_burst) |-> ((bus_alo[1:0] == 2'b00) && (!cfg_burst8 || !bus_alo[2])));
  // R5
  no_page_cross_chk: assert property (@(posedge clk) disable iff (!rst_i)
    bus_as |-> ((addr_q >> PAGE_LG) == (chunk_last >> PAGE_LG)));
  // R6
  alo_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_data && bus_rdy && (beats_q != LW'(1))) |=> (bus_alo == $past(bus_alo) + 3'd1));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_data && !bus_rdy) |=> ((state_q == ST_DATA) && $stable(bus_alo)));
  // R7
  strobe_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (fifo_rd_en || fifo_wr_en) |-> bus_rdy);
  // R8
  write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_i)
    fifo_rd_en |-> (bus_oe && bus_we));
  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    par_err |=> par_err);
  // R11
  done_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> (!bus_req && req_ready));
endmodule

// File: tb/tb_burst_bus_master.sv
`timescale 1ns/1ps
module tb_burst_bus_master;
  localparam int AW = 30;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_burst8, cfg_big_endian, cfg_addr_on_data;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_count;
  logic fifo_rd_en, fifo_wr_en;
  logic [31:0] fifo_rd_data, fifo_wr_data;
  logic bus_req, bus_gnt, bus_as, bus_burst, bus_we, bus_oe, bus_rdy;
  logic [AW-1:0] bus_addr;
  logic [2:0] bus_alo;
  logic [31:0] bus_dout, bus_din;
  logic [3:0] bus_pout, bus_pin;
  logic done, par_err;
  logic [CW-1:0] done_words;

  burst_bus_master #(.AW(AW), .CW(CW), .PAGE_WORDS(64)) dut (.*);

  typedef struct packed {
    logic [15:0] addr; logic [7:0] cnt; logic wr; logic b8; logic be;
    logic mx; logic wt; logic [7:0] txn; logic [7:0] bst;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0010, 8'd8,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  8'd1},
    '{16'h0013, 8'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd12, 8'd0},
    '{16'h0013, 8'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6,  8'd2},
    '{16'h0020, 8'd16, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2,  8'd2},
    '{16'h003E, 8'd6,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  8'd1},
    '{16'h0005, 8'd1,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  8'd0},
    '{16'h0018, 8'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  8'd0},
    '{16'h001C, 8'd4,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  8'd1}
  };

  int errs = 0, checks = 0;

  function automatic logic [31:0] swp(input logic [31:0] w, input logic be);
    return be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction
  function automatic logic [3:0] opar(input logic [31:0] w);
    return {~^w[31:24], ~^w[23:16], ~^w[15:8], ~^w[7:0]};
  endfunction
  function automatic logic [31:0] rdfun(input logic [AW-1:0] a);
    return {8'hA5, a[7:0], 8'h3C, ~a[7:0]};
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // context shared with the bus responder
  logic cur_we = 1'b0, cur_be = 1'b0, cur_b8 = 1'b0, cur_mx = 1'b0, cur_wt = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  int txn_n = 0, bst_n = 0, beats_left = 0, src_idx = 0;
  logic xfer_err = 1'b0, req_err = 1'b0, done_seen = 1'b0, inject = 1'b0;
  logic [CW-1:0] done_w = '0;
  logic [7:0] lf = 8'h5A;

  assign fifo_rd_data = 32'h1122_3300 + 32'(src_idx);

  // bus responder and monitor
  initial begin
    logic [AW-1:0] ba;
    bus_gnt = 1'b0; bus_rdy = 1'b0; bus_din = '0; bus_pin = '0;
    forever begin
      @(negedge clk);
      bus_gnt = bus_req;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      bus_rdy = cur_wt ? (lf[0] | lf[3]) : 1'b1;
      #0.5;
      if (bus_as) begin
        txn_n++;
        if (bus_burst) bst_n++;
        beats_left = bus_burst ? (cur_b8 ? 8 : 4) : 1;
        if (!bus_gnt) req_err = 1'b1;                                   // R2
        if (bus_addr != exp_addr || bus_we != cur_we) xfer_err = 1'b1;  // R3
        if (cur_mx && !(bus_oe && bus_dout == {2'b00, bus_addr})) xfer_err = 1'b1;
      end else if (beats_left > 0) begin
        ba = {bus_addr[AW-1:3], bus_alo};
        if (!cur_we) begin
          bus_din = rdfun(ba);
          bus_pin = opar(bus_din) ^ (inject ? 4'b0001 : 4'b0000);
        end
        #0.5;
        if (bus_rdy) begin
          if (ba != exp_addr) xfer_err = 1'b1;                          // R6
          if (cur_we) begin                                             // R8, R10
            if (!fifo_rd_en || fifo_wr_en || !bus_oe ||
                bus_dout != swp(32'h1122_3300 + 32'(src_idx), cur_be) ||
                bus_pout != opar(bus_dout)) xfer_err = 1'b1;
            src_idx++;
          end else begin                                                // R9
            if (!fifo_wr_en || fifo_rd_en || fifo_wr_data != swp(rdfun(ba), cur_be))
              xfer_err = 1'b1;
            inject = 1'b0;
          end
          exp_addr++;
          beats_left--;
        end else if (fifo_rd_en || fifo_wr_en) begin
          xfer_err = 1'b1;                                              // R7
        end
      end
      if (done) begin
        done_seen = 1'b1;
        done_w = done_words;
        if (bus_req) req_err = 1'b1;                                    // R2
      end
    end
  end

  task automatic run(input vec_t v, input logic exp_perr);
    cfg_burst8 = v.b8; cfg_big_endian = v.be; cfg_addr_on_data = v.mx;
    cur_we = v.wr; cur_be = v.be; cur_b8 = v.b8; cur_mx = v.mx; cur_wt = v.wt;
    exp_addr = AW'(v.addr); txn_n = 0; bst_n = 0; src_idx = 0;
    xfer_err = 1'b0; req_err = 1'b0; done_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(v.addr); req_count = CW'(v.cnt); req_write = v.wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !done_seen; i++) begin
      @(negedge clk); #2;
    end
    chk("R11 done seen", done_seen, 32'(done_seen), 1);
    chk("R11 done_words", done_w == CW'(v.cnt), 32'(done_w), 32'(v.cnt));
    chk("R4 transaction count", txn_n == int'(v.txn), txn_n, 32'(v.txn));
    chk("R4 R5 burst count", bst_n == int'(v.bst), bst_n, 32'(v.bst));
    chk("R3 R6 R7 R8 R9 beat address/data", !xfer_err, 32'(xfer_err), 0);
    chk("R2 grant and release", !req_err, 32'(req_err), 0);
    chk("R10 par_err", par_err == exp_perr, 32'(par_err), 32'(exp_perr));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0; req_write = 1'b0;
    cfg_burst8 = 1'b0; cfg_big_endian = 1'b0; cfg_addr_on_data = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset ready", req_ready === 1'b1, 32'(req_ready), 1);
    chk("R12 reset quiet", {bus_req, bus_as, done, par_err} === 4'b0, 32'({bus_req, bus_as, done, par_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R12 after release", req_ready && !bus_req && !par_err, 32'({req_ready, bus_req, par_err}), 32'b100);

    foreach (VECS[i]) run(VECS[i], 1'b0);

    // R1: zero-length request
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(16'h0040); req_count = '0; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R1 zero count done", done && done_words == '0 && !bus_req, 32'({done, bus_req}), 32'b10);
    @(negedge clk); #1;
    chk("R11 done one cycle", !done && !bus_req && req_ready, 32'({done, bus_req, req_ready}), 32'b001);

    // R10: bad parity on a read, then sticky through a clean write
    inject = 1'b1;
    run('{16'h0040, 8'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 8'd0}, 1'b1);
    run('{16'h0048, 8'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 8'd1}, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 R10 reset clears par_err", !par_err, 32'(par_err), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run('{16'h0050, 8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2, 8'd2}, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule